// File: doc/BRIEF.md
# Interrupt Vector and DMA Request Unit

This unit holds the event flags of a serial-bus master controller and condenses them into one level-sensitive interrupt line plus a receive and a transmit DMA request. The transfer engine raises individual flags through a vector of one-cycle set pulses. Software controls the unit through a small register window: an interrupt-enable register, a status register, a vector register, a DMA-enable register and a test register.

A revision input picks between two software models. On older revisions (below the `NEW_REV` parameter, 0x34 by default) status is read-only and flags are retired one at a time by reading the vector register, which returns the number of the lowest pending enabled source and clears it. On newer revisions the vector register reads zero, status bits are cleared by writing ones, the enable mask grows from five to six bits, and a test write can force all six source flags.

Register access is single-cycle. Read data on `rdata` is combinational from the current state and `reg_sel`. Side effects of a read or write (including a vector read clearing a flag) appear after the clock edge at which `rd_en` or `wr_en` is sampled high. `reg_sel` codes: 0 enable, 1 status, 2 vector, 3 DMA-enable, 4 test.

Top module: `ivu_top`

## Requirements
- R1: After reset, status, enable and DMA-enable are all zero, and `irq`, `rx_dma_req` and `tx_dma_req` are low.
- R2: `irq` is high exactly when some status bit in 5:0 is set and its enable bit is also set.
- R3: `rx_dma_req` equals status bit 3 while DMA-enable bit 15 is set, and `tx_dma_req` equals status bit 4 while DMA-enable bit 7 is set. Each request is low otherwise.
- R4: On an older revision, reading the vector register (code 2) returns one plus the index of the lowest set bit of (status[5:0] AND enable), or 0 if there is none. That status bit clears after the read.
- R5: On a newer revision, a vector read returns 0 and changes no status bit.
- R6: A write to the enable register (code 0) stores wdata[4:0] with bit 5 zero on an older revision. It stores wdata[5:0] on a newer revision.
- R7: On a newer revision, a status write (code 1) clears the status bits set in both wdata and 0x0027. Bits 3 and 4 are not cleared. On an older revision, a status write changes nothing.
- R8: A DMA-enable write (code 3) keeps only wdata bits 15 and 7. Bit 15 set clears enable bit 3, and bit 7 set clears enable bit 4.
- R9: A status read returns the stored flags with bit 12 replaced by the live `bus_busy` input. Bit 12 is never stored.
- R10: On a newer revision, a test write (code 4) with wdata bit 11 set sets status bits 5:0. On an older revision it has no effect on status.
- R11: When a set pulse and a software clear (status write or vector read) target the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| revision | input | 8 | Revision code; at or above NEW_REV selects newer model |
| reg_sel | input | 3 | Register select code |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (vector read side effect) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register |
| hw_set | input | 16 | One-cycle set pulses per status bit from the transfer engine |
| bus_busy | input | 1 | Live bus-busy indication |
| irq | output | 1 | Level interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
A hardware set pulse can coincide with a software clear of the same flag, either through a write-one-to-clear status write or through a vector read that retires that flag. The bench drives both in one cycle from a single stimulus task. It checks that the vector value returned is the one pending before the edge and that the flag still reads back as set afterwards. A clear of a different bit in the same cycle must still take effect, so the bench can tell "set wins" apart from "clear was dropped".

// File: rtl/ivu_pkg.sv
package ivu_pkg;
    localparam int DW = 16;

    typedef enum logic [2:0] {
        SEL_IE   = 3'd0,
        SEL_STAT = 3'd1,
        SEL_VEC  = 3'd2,
        SEL_BUF  = 3'd3,
        SEL_TEST = 3'd4
    } sel_e;

    localparam int BIT_RRDY  = 3;
    localparam int BIT_XRDY  = 4;
    localparam int BIT_BUSY  = 12;
    localparam int BUF_RXEN  = 15;
    localparam int BUF_TXEN  = 7;
    localparam int TEST_FRC  = 11;

    localparam logic [DW-1:0] W1C_MASK   = 16'h0027;
    localparam logic [DW-1:0] STORE_MASK = ~(16'h1 << BIT_BUSY);
endpackage

// File: rtl/ivu_prio_enc.sv
module ivu_prio_enc #(
    parameter int N  = 6,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        valid = |req;
    end
endmodule

// File: rtl/ivu_req_gen.sv
module ivu_req_gen #(
    parameter int N = 6
) (
    input  logic [N-1:0] src,
    input  logic [N-1:0] ena,
    input  logic         rrdy,
    input  logic         xrdy,
    input  logic         rx_en,
    input  logic         tx_en,
    output logic         irq,
    output logic         rx_req,
    output logic         tx_req
);
    always_comb begin
        irq    = |(src & ena);
        rx_req = rx_en & rrdy;
        tx_req = tx_en & xrdy;
    end
endmodule

// File: rtl/ivu_top.sv
module ivu_top
    import ivu_pkg::*;
#(
    parameter int          N_SRC   = 6,
    parameter logic [7:0]  NEW_REV = 8'h34,
    localparam int         IW      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    revision,
    input  logic [2:0]    reg_sel,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata,
    input  logic [15:0]   hw_set,
    input  logic          bus_busy,
    output logic          irq,
    output logic          rx_dma_req,
    output logic          tx_dma_req
);
    typedef struct packed {
        logic [DW-1:0]    stat;
        logic [N_SRC-1:0] ie;
        logic             rx_en;
        logic             tx_en;
    } state_t;

    state_t s_d, s_q;

    logic             is_new;
    logic [N_SRC-1:0] ie_mask;
    logic [N_SRC-1:0] pend;
    logic             pe_valid;
    logic [IW-1:0]    pe_idx;
    logic [DW-1:0]    clr_d, frc_d, vec_val;
    logic             vec_rd;

    assign is_new  = (revision >= NEW_REV);
    assign ie_mask = is_new ? {N_SRC{1'b1}} : {1'b0, {(N_SRC-1){1'b1}}};
    assign pend    = s_q.stat[N_SRC-1:0] & s_q.ie;
    assign vec_rd  = rd_en && (reg_sel == SEL_VEC) && !is_new;

    ivu_prio_enc #(.N(N_SRC)) u_pe (
        .req   (pend),
        .valid (pe_valid),
        .idx   (pe_idx)
    );

    assign vec_val = pe_valid ? (DW'(pe_idx) + DW'(1)) : '0;

    always_comb begin
        s_d   = s_q;
        clr_d = '0;
        frc_d = '0;
        if (wr_en) begin
            case (reg_sel)
                SEL_IE:   s_d.ie = wdata[N_SRC-1:0] & ie_mask;
                SEL_STAT: if (is_new) clr_d = wdata & W1C_MASK;
                SEL_BUF: begin
                    s_d.rx_en = wdata[BUF_RXEN];
                    s_d.tx_en = wdata[BUF_TXEN];
                    if (wdata[BUF_RXEN]) s_d.ie[BIT_RRDY] = 1'b0;
                    if (wdata[BUF_TXEN]) s_d.ie[BIT_XRDY] = 1'b0;
                end
                SEL_TEST: if (is_new && wdata[TEST_FRC]) frc_d[N_SRC-1:0] = '1;
                default: ;
            endcase
        end
        if (vec_rd && pe_valid) clr_d[pe_idx] = 1'b1;
        s_d.stat = ((s_q.stat & ~clr_d) | frc_d | hw_set) & STORE_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (reg_sel)
            SEL_IE:   rdata = DW'(s_q.ie);
            SEL_STAT: rdata = (s_q.stat & STORE_MASK) | (DW'(bus_busy) << BIT_BUSY);
            SEL_VEC:  rdata = is_new ? '0 : vec_val;
            SEL_BUF:  rdata = (DW'(s_q.rx_en) << BUF_RXEN) | (DW'(s_q.tx_en) << BUF_TXEN);
            default:  rdata = '0;
        endcase
    end

    ivu_req_gen #(.N(N_SRC)) u_rg (
        .src    (s_q.stat[N_SRC-1:0]),
        .ena    (s_q.ie),
        .rrdy   (s_q.stat[BIT_RRDY]),
        .xrdy   (s_q.stat[BIT_XRDY]),
        .rx_en  (s_q.rx_en),
        .tx_en  (s_q.tx_en),
        .irq    (irq),
        .rx_req (rx_dma_req),
        .tx_req (tx_dma_req)
    );

    a_r3_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> s_q.rx_en);
    a_r4_vec_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && pe_valid && !hw_set[pe_idx]) |=> !s_q.stat[$past(pe_idx)]);
    a_r6_old_ie_width: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_IE && !is_new) |=> !s_q.ie[N_SRC-1]);
    a_r7_old_stat_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_STAT && !is_new && !rd_en && hw_set == '0) |=> $stable(s_q.stat));
    a_r8_dma_drops_ie: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_BUF && wdata[BUF_RXEN]) |=> !s_q.ie[BIT_RRDY]);
    a_r10_force: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_TEST && is_new && wdata[TEST_FRC]) |=> (&s_q.stat[N_SRC-1:0]));
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set[0] |=> s_q.stat[0]);
endmodule

// File: tb/ivu_top_tb.sv
module ivu_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  revision = 8'h11;
    logic [2:0]  reg_sel = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] wdata = '0, rdata, hw_set = '0;
    logic        bus_busy = 1'b0;
    logic        irq, rx_dma_req, tx_dma_req;
    int          total = 0, bad = 0;

    always #5 clk = ~clk;

    ivu_top u_dut (
        .clk(clk), .rst_n(rst_n), .revision(revision), .reg_sel(reg_sel),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .hw_set(hw_set), .bus_busy(bus_busy), .irq(irq),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
    );

    localparam logic [7:0] OLD = 8'h11, NEW = 8'h34;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one access cycle; rdata captured before the edge
    task automatic op(input logic [2:0] sel, input logic w, input logic r,
                      input logic [15:0] d, input logic [15:0] hs, output logic [15:0] q);
        @(negedge clk);
        reg_sel = sel; wr_en = w; rd_en = r; wdata = d; hw_set = hs;
        #1 q = rdata;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; hw_set = '0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d);
        logic [15:0] q;
        op(sel, 1'b1, 1'b0, d, 16'h0, q);
    endtask

    task automatic rd(input logic [2:0] sel, output logic [15:0] q);
        op(sel, 1'b0, 1'b1, 16'h0, 16'h0, q);
    endtask

    task automatic pulse(input logic [15:0] hs);
        logic [15:0] q;
        op(3'd0, 1'b0, 1'b0, 16'h0, hs, q);
    endtask

    task automatic do_reset(input logic [7:0] rv);
        @(negedge clk);
        rst_n = 1'b0; revision = rv; bus_busy = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [15:0] q;
        do_reset(OLD);
        rd(3'd1, q); chk("R1 status", q, 16'h0);
        rd(3'd0, q); chk("R1 enable", q, 16'h0);
        rd(3'd3, q); chk("R1 dma-enable", q, 16'h0);
        chk("R1 outputs", {13'b0, irq, rx_dma_req, tx_dma_req}, 16'h0);
    endtask

    task automatic t_irq_ie();
        logic [15:0] q;
        do_reset(OLD);
        pulse(16'h0004);
        chk("R2 irq masked", {15'b0, irq}, 16'h0);
        wr(3'd0, 16'h0004);
        chk("R2 irq enabled", {15'b0, irq}, 16'h1);
        wr(3'd0, 16'h0002);
        chk("R2 irq other bit", {15'b0, irq}, 16'h0);
        wr(3'd0, 16'hFFFF); rd(3'd0, q);
        chk("R6 old width", q, 16'h001F);
        do_reset(NEW);
        wr(3'd0, 16'hFFFF); rd(3'd0, q);
        chk("R6 new width", q, 16'h003F);
    endtask

    task automatic t_vec_old();
        logic [15:0] q;
        do_reset(OLD);
        wr(3'd0, 16'h001F);
        pulse(16'h002A);
        rd(3'd2, q); chk("R4 first vector", q, 16'h0002);
        rd(3'd1, q); chk("R4 bit1 cleared", q, 16'h0028);
        rd(3'd2, q); chk("R4 second vector", q, 16'h0004);
        rd(3'd2, q); chk("R4 none pending", q, 16'h0000);
        rd(3'd1, q); chk("R4 unenabled bit5 kept", q, 16'h0020);
    endtask

    task automatic t_vec_new();
        logic [15:0] q;
        do_reset(NEW);
        wr(3'd0, 16'h003F);
        pulse(16'h0001);
        rd(3'd2, q); chk("R5 vector reads zero", q, 16'h0);
        rd(3'd1, q); chk("R5 status untouched", q, 16'h0001);
    endtask

    task automatic t_w1c();
        logic [15:0] q;
        do_reset(NEW);
        pulse(16'h003F);
        wr(3'd1, 16'hFFFF); rd(3'd1, q);
        chk("R7 w1c keeps ready bits", q, 16'h0018);
        do_reset(OLD);
        pulse(16'h0001);
        wr(3'd1, 16'h0001); rd(3'd1, q);
        chk("R7 old read-only", q, 16'h0001);
    endtask

    task automatic t_dma();
        logic [15:0] q;
        do_reset(OLD);
        wr(3'd0, 16'h001F);
        wr(3'd3, 16'hFFFF); rd(3'd3, q);
        chk("R8 kept bits", q, 16'h8080);
        rd(3'd0, q); chk("R8 ie bits dropped", q, 16'h0007);
        pulse(16'h0008);
        chk("R3 rx req only", {14'b0, rx_dma_req, tx_dma_req}, 16'h2);
        pulse(16'h0010);
        chk("R3 both req", {14'b0, rx_dma_req, tx_dma_req}, 16'h3);
        chk("R2 ready bits not enabled", {15'b0, irq}, 16'h0);
        wr(3'd3, 16'h0000);
        chk("R3 gated off", {14'b0, rx_dma_req, tx_dma_req}, 16'h0);
    endtask

    task automatic t_busy();
        logic [15:0] q;
        do_reset(OLD);
        pulse(16'h1000);
        rd(3'd1, q); chk("R9 bit12 not stored", q, 16'h0);
        bus_busy = 1'b1;
        rd(3'd1, q); chk("R9 live busy", q, 16'h1000);
        bus_busy = 1'b0;
    endtask

    task automatic t_force();
        logic [15:0] q;
        do_reset(NEW);
        wr(3'd4, 16'h0800); rd(3'd1, q);
        chk("R10 forced", q, 16'h003F);
        do_reset(OLD);
        wr(3'd4, 16'h0800); rd(3'd1, q);
        chk("R10 old no effect", q, 16'h0000);
    endtask

    task automatic t_race();
        logic [15:0] q;
        do_reset(NEW);
        pulse(16'h0003);
        op(3'd1, 1'b1, 1'b0, 16'h0003, 16'h0001, q);
        rd(3'd1, q); chk("R11 w1c vs set", q, 16'h0001);
        do_reset(OLD);
        wr(3'd0, 16'h001F);
        pulse(16'h0002);
        op(3'd2, 1'b0, 1'b1, 16'h0, 16'h0002, q);
        chk("R11 vector value", q, 16'h0002);
        rd(3'd1, q); chk("R11 vector vs set", q, 16'h0002);
    endtask

    initial begin
        t_reset();
        t_irq_ie();
        t_vec_old();
        t_vec_new();
        t_w1c();
        t_dma();
        t_busy();
        t_force();
        t_race();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule